// File: doc/BRIEF.md
# Secondary-Bus Burst Tenure Timer

This block bounds how long a bridge, while it is master on its secondary bus, keeps bursting data. Software programs a 5-bit tenure field in an 8-bit configuration register. Each time the local master starts a transaction by driving FRAME# low, the block loads a countdown with the field value times eight. When the countdown reaches zero the timer is expired. From then on, the block asks the master sequencer to end the burst on any clock where the bus grant has been withdrawn (GNT# high). While the grant is still held, the master may carry on.

The end-burst request is combinational from `frame_n`, `gnt_n` and the registered timer state. The master sequencer therefore sees it on the same clock in which the grant drops. The configuration read port is also combinational and returns the register only at its own offset.

Top module: `tenure_timer_top`

## Requirements
- R1: After synchronous reset the register at offset 0x1B reads 0x00, and `end_burst` is low while `frame_n` is high.
- R2: A write with `cfg_wr` high and `cfg_addr` = 0x1B stores `cfg_wdata[7:3]` as the tenure field, and a read of 0x1B on any later cycle returns it in `cfg_rdata[7:3]`.
- R3: Bits 2:0 of the register always read 0, and the values written to them have no effect.
- R4: Writes to any other offset leave the register unchanged, and reads of any other offset return 0x00.
- R5: A transaction starts on the first clock on which `frame_n` is low after a clock on which it was high. `end_burst` stays low for the first field×8 clocks of the transaction, counting the start clock as clock 0.
- R6: From clock field×8 of a transaction onward, `end_burst` is high on every clock on which `frame_n` is low and `gnt_n` is high, including the clock on which the grant drops.
- R7: `end_burst` is never high while `gnt_n` is low.
- R8: With a field of 0 the timer counts as expired on the start clock itself, so `end_burst` can be high on clock 0.
- R9: Once expired, the timer stays expired while `frame_n` is high. The next transaction start reloads it from the current field.
- R10: `end_burst` is never high while `frame_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration byte offset for reads and writes |
| cfg_wr | input | 1 | Write strobe for `cfg_wdata` at `cfg_addr` |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| frame_n | input | 1 | Observed FRAME# of the local master, active low |
| gnt_n | input | 1 | Observed bus grant, active low |
| end_burst | output | 1 | Request to the master sequencer to deassert FRAME# |

## Verification
A configuration write takes effect at the clock edge that ends its cycle. The readback is therefore checked on a later cycle, and a read result is due in the same cycle its address is presented. `end_burst` is due in the same cycle as the `frame_n`/`gnt_n` values that cause it. The clock-0 reference is the first low cycle of `frame_n`, so expiry falls exactly field×8 cycles later. The driver sets inputs on the falling edge and queues the expected value for that cycle. The monitor compares each queued value shortly after the same falling edge, once the combinational outputs have settled and well before the next rising edge.

// File: rtl/tenure_pkg.sv
package tenure_pkg;

    localparam int TENURE_FIELD_W = 5;
    localparam int TENURE_STEP_LOG2 = 3;
    localparam int CFG_REG_W = 8;
    localparam int CFG_ADDR_W = 8;
    localparam logic [CFG_ADDR_W-1:0] TENURE_REG_OFFSET = 8'h1B;

    typedef struct packed {
        logic frame_active;
        logic grant_held;
    } bus_obs_t;

    typedef enum logic [1:0] {
        TS_IDLE    = 2'd0,
        TS_RUNNING = 2'd1,
        TS_EXPIRED = 2'd2
    } tenure_state_e;

    function automatic bus_obs_t decode_obs(input logic frame_n, input logic gnt_n);
        bus_obs_t o;
        o.frame_active = ~frame_n;
        o.grant_held   = ~gnt_n;
        return o;
    endfunction

endpackage

// File: rtl/tenure_cfg_reg.sv
module tenure_cfg_reg
    import tenure_pkg::*;
#(
    parameter int ADDR_W = CFG_ADDR_W,
    parameter int REG_W = CFG_REG_W,
    parameter int FIELD_W = TENURE_FIELD_W,
    parameter logic [ADDR_W-1:0] OFFSET = TENURE_REG_OFFSET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [FIELD_W-1:0] field
);
    localparam int FIELD_LSB = REG_W - FIELD_W;
    localparam logic [REG_W-1:0] WR_MASK = {{FIELD_W{1'b1}}, {FIELD_LSB{1'b0}}};

    logic [REG_W-1:0] reg_q;
    logic             hit;

    assign hit = (addr == OFFSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (wr && hit) begin
            reg_q <= wdata & WR_MASK;
        end
    end

    assign rdata = hit ? reg_q : '0;
    assign field = reg_q[REG_W-1:FIELD_LSB];

endmodule

// File: rtl/tenure_countdown.sv
module tenure_countdown
    import tenure_pkg::*;
#(
    parameter int FIELD_W = TENURE_FIELD_W,
    parameter int STEP_LOG2 = TENURE_STEP_LOG2,
    localparam int TW = FIELD_W + STEP_LOG2
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_obs_t           obs,
    input  logic [FIELD_W-1:0] field,
    output logic               expired,
    output logic               start,
    output tenure_state_e      state,
    output logic [TW-1:0]      timer
);
    logic [TW-1:0] timer_q;
    logic [TW-1:0] load_val;
    logic          prev_active_q;

    assign load_val = TW'(field) << STEP_LOG2;
    assign start    = obs.frame_active && !prev_active_q;
    assign expired  = start ? (load_val == '0) : (timer_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_active_q <= 1'b0;
            timer_q       <= '0;
        end else begin
            prev_active_q <= obs.frame_active;
            if (start) begin
                timer_q <= (load_val == '0) ? '0 : load_val - 1'b1;
            end else if (obs.frame_active && timer_q != '0) begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

    always_comb begin
        if (!obs.frame_active)  state = TS_IDLE;
        else if (expired)       state = TS_EXPIRED;
        else                    state = TS_RUNNING;
    end

    assign timer = timer_q;

endmodule

// File: rtl/tenure_release.sv
module tenure_release
    import tenure_pkg::*;
(
    input  bus_obs_t      obs,
    input  tenure_state_e state,
    output logic          end_burst
);
    always_comb begin
        end_burst = 1'b0;
        if (state == TS_EXPIRED && !obs.grant_held) begin
            end_burst = 1'b1;
        end
    end
endmodule

// File: rtl/tenure_timer_top.sv
module tenure_timer_top
    import tenure_pkg::*;
#(
    parameter int ADDR_W = CFG_ADDR_W,
    parameter int REG_W = CFG_REG_W,
    parameter int FIELD_W = TENURE_FIELD_W,
    parameter int STEP_LOG2 = TENURE_STEP_LOG2,
    parameter logic [ADDR_W-1:0] OFFSET = TENURE_REG_OFFSET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              frame_n,
    input  logic              gnt_n,
    output logic              end_burst
);
    localparam int TW = FIELD_W + STEP_LOG2;

    bus_obs_t           obs;
    logic [FIELD_W-1:0] field_w;
    logic [TW-1:0]      timer_w;
    logic               expired_w;
    logic               start_w;
    tenure_state_e      state_w;

    assign obs = decode_obs(frame_n, gnt_n);

    tenure_cfg_reg #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .FIELD_W(FIELD_W), .OFFSET(OFFSET)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .field(field_w)
    );

    tenure_countdown #(
        .FIELD_W(FIELD_W), .STEP_LOG2(STEP_LOG2)
    ) u_cnt (
        .clk(clk), .rst(rst), .obs(obs), .field(field_w),
        .expired(expired_w), .start(start_w), .state(state_w), .timer(timer_w)
    );

    tenure_release u_rel (
        .obs(obs), .state(state_w), .end_burst(end_burst)
    );

endmodule

// File: rtl/tenure_timer_checker.sv
module tenure_timer_checker #(
    parameter int ADDR_W = 8,
    parameter int REG_W = 8,
    parameter int FIELD_W = 5,
    parameter int STEP_LOG2 = 3,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h1B,
    localparam int TW = FIELD_W + STEP_LOG2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              frame_n,
    input logic              gnt_n,
    input logic              end_burst,
    input logic [FIELD_W-1:0] field,
    input logic [TW-1:0]     timer
);
    localparam int FIELD_LSB = REG_W - FIELD_W;

    logic          prev_low_q;
    logic [TW:0]   age_q;
    logic [TW:0]   limit_q;
    logic          first_low;
    logic [TW:0]   limit_now;

    assign first_low = !frame_n && !prev_low_q;
    assign limit_now = (TW + 1)'(field) << STEP_LOG2;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_low_q <= 1'b0;
            age_q      <= '0;
            limit_q    <= '0;
        end else begin
            prev_low_q <= !frame_n;
            if (first_low) begin
                age_q   <= (TW + 1)'(1);
                limit_q <= limit_now;
            end else if (!frame_n && age_q != {(TW + 1){1'b1}}) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    // R10
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        frame_n |-> !end_burst);

    // R7
    a_r7_grant_keeps: assert property (@(posedge clk) disable iff (rst)
        !gnt_n |-> !end_burst);

    // R3
    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[FIELD_LSB-1:0] == '0);

    // R4
    a_r4_other_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr != OFFSET) |-> (cfg_rdata == '0));

    // R2
    a_r2_field_written: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == OFFSET) |=> (field == $past(cfg_wdata[REG_W-1:FIELD_LSB])));

    // R5, R8
    a_r5_no_early_end: assert property (@(posedge clk) disable iff (rst)
        (end_burst && first_low) |-> (field == '0));
    a_r5_no_early_end_run: assert property (@(posedge clk) disable iff (rst)
        (end_burst && !first_low) |-> (age_q >= limit_q));

    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        $past(frame_n) |-> $stable(timer));

endmodule

bind tenure_timer_top tenure_timer_checker #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .FIELD_W(FIELD_W),
    .STEP_LOG2(STEP_LOG2), .OFFSET(OFFSET)
) u_chk (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_n(frame_n),
    .gnt_n(gnt_n), .end_burst(end_burst), .field(field_w), .timer(timer_w)
);

// File: tb/test_tenure_timer_top.sv
module test_tenure_timer_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_addr = 8'h00;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       frame_n = 1'b1;
    logic       gnt_n = 1'b1;
    logic       end_burst;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         is_read;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    tenure_timer_top i_tenure_timer_top (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_n(frame_n),
        .gnt_n(gnt_n), .end_burst(end_burst)
    );

    // monitor: pops the expectation queued for this cycle
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = it.is_read ? cfg_rdata : {7'd0, end_burst};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%02h expected=%02h at %0t", it.req, act, it.exp, $time);
            end
        end
    end

    task automatic bus(input logic fn, input logic gn, input logic exp_eb, input string req);
        @(negedge clk);
        cfg_wr  = 1'b0;
        frame_n = fn;
        gnt_n   = gn;
        sb.push_back('{1'b0, {7'd0, exp_eb}, req});
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        cfg_wr   = 1'b0;
        cfg_addr = a;
        sb.push_back('{1'b1, exp, req});
    endtask

    // n cycles of transaction with grant held by gn, expectation e
    task automatic run(input int n, input logic gn, input logic e, input string req);
        for (int i = 0; i < n; i++) bus(1'b0, gn, e, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_read(8'h1B, 8'h00, "R1");
        bus(1'b1, 1'b1, 1'b0, "R1");

        cfg_write(8'h1B, 8'hFF);
        cfg_read(8'h1B, 8'hF8, "R2");
        cfg_read(8'h1B, 8'hF8, "R3");
        cfg_write(8'h1C, 8'h55);
        cfg_read(8'h1B, 8'hF8, "R4");
        cfg_read(8'h1C, 8'h00, "R4");
        cfg_read(8'h1A, 8'h00, "R4");

        // field 1 -> 8 clocks, reserved bits written nonzero
        cfg_write(8'h1B, 8'h0E);
        cfg_read(8'h1B, 8'h08, "R3");
        bus(1'b1, 1'b1, 1'b0, "R10");
        run(8, 1'b1, 1'b0, "R5");
        bus(1'b0, 1'b1, 1'b1, "R6");
        bus(1'b1, 1'b1, 1'b0, "R10");

        // expired with grant still held, then grant drops
        run(8, 1'b0, 1'b0, "R5");
        run(4, 1'b0, 1'b0, "R7");
        bus(1'b0, 1'b1, 1'b1, "R6");
        bus(1'b0, 1'b0, 1'b0, "R7");
        bus(1'b0, 1'b1, 1'b1, "R6");
        bus(1'b1, 1'b1, 1'b0, "R10");

        // zero field expires on start clock
        cfg_write(8'h1B, 8'h07);
        cfg_read(8'h1B, 8'h00, "R8");
        bus(1'b1, 1'b1, 1'b0, "R10");
        bus(1'b0, 1'b1, 1'b1, "R8");
        bus(1'b1, 1'b1, 1'b0, "R10");

        // stays expired while idle, reload on next start
        cfg_write(8'h1B, 8'h10);
        run(20, 1'b0, 1'b0, "R7");
        bus(1'b1, 1'b1, 1'b0, "R9");
        bus(1'b1, 1'b1, 1'b0, "R9");
        run(16, 1'b1, 1'b0, "R9");
        bus(1'b0, 1'b1, 1'b1, "R9");
        bus(1'b1, 1'b1, 1'b0, "R10");

        // largest field: 248 clocks
        cfg_write(8'h1B, 8'hF8);
        bus(1'b1, 1'b1, 1'b0, "R10");
        run(248, 1'b1, 1'b0, "R5");
        bus(1'b0, 1'b1, 1'b1, "R6");
        bus(1'b1, 1'b1, 1'b0, "R10");

        // reset returns register and output to idle
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cfg_read(8'h1B, 8'h00, "R1");
        bus(1'b1, 1'b1, 1'b0, "R1");

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule